// File: doc/BRIEF.md
# SPI DMA Control and FIFO Bridge

This block sits between a memory DMA engine and the shift logic of an SPI data port. A four-entry FIFO carries the words between the two sides. A memory-mapped control word sets what the bridge does: whether it runs, which way data flows, whether the FIFO is held empty, and which interrupts may fire. Software also loads a word count. Each word that passes the DMA side of the bridge lowers that count by one. When the count reaches zero, the bridge stops requesting DMA traffic and can raise a one-cycle completion interrupt.

In transmit mode the bridge asks the DMA engine for words until the FIFO is full. The SPI logic takes a word from the head of the FIFO each time it starts shifting one out. In receive mode the SPI logic pushes each word it has shifted in, and the DMA engine drains the FIFO into memory. Two sticky error flags record problems on the SPI side. Underrun is set when the SPI logic starts a transmit word while the FIFO is empty. Overflow is set when a received word arrives while the FIFO is full. Each flag can only be set in its own mode. A flush bit stays set until software writes zero to it. While it is set, the FIFO and both error flags are held clear.

Top module: `spi_dma_bridge`

## Requirements
- R1: After reset, every control bit, the word count and both error flags read 0, and `done_irq`, `err_irq`, `dma_req` and `dma_rd_valid` are 0.
- R2: `reg_addr`=0 selects the control word and `reg_addr`=1 selects the word count. In the control word, bit 0 is run, bit 1 is direction (0 transmit, 1 receive), bit 2 is the completion interrupt enable, bit 4 is a stored chaining flag, bit 7 is flush and bit 8 is the error interrupt enable. Each of these bits reads back the value last written to it. Bits 3, 5, 6 and 11 to 15 always read 0. Writes to bit 9 and bit 10 have no effect.
- R3: The FIFO holds at most 4 words and delivers them in the order they were written. In transmit mode, `dma_req` is high only while the bridge is running, not flushing, not full and the count is non-zero. `dma_wr` is accepted only while `dma_req` is high.
- R4: In transmit mode, `spi_tx_data` shows the head word. A `spi_tx_start` while the FIFO is not empty removes that word.
- R5: In receive mode, a `spi_rx_valid` while the FIFO is not full stores `spi_rx_data`. `dma_rd_valid` is high while the FIFO is not empty, the count is non-zero, and the bridge is running and not flushing. `dma_rd` while `dma_rd_valid` is high removes the head word, which is shown on `dma_rdata`.
- R6: The overflow flag (control bit 9) is set when a `spi_rx_valid` arrives in receive mode while the FIFO holds 4 words, and that word is dropped. The flag stays set until a flush. A `spi_rx_valid` in transmit mode never sets it.
- R7: The underrun flag (control bit 10) is set when a `spi_tx_start` arrives in transmit mode while the FIFO is empty. The flag stays set until a flush. A `spi_tx_start` in receive mode never sets it.
- R8: A write with bit 7 set empties the FIFO and clears both flags at that edge. While bit 7 stays 1, the FIFO stays empty, both flags stay 0 and both DMA strobes are 0. Bit 7 stays 1 until a write puts 0 in it.
- R9: Each accepted DMA-side word lowers the count by 1. A write to the count takes priority over the decrement in the same cycle. At a count of 0, `dma_req` and `dma_rd_valid` are 0. When a decrement takes the count from 1 to 0 and bit 2 is set, `done_irq` is high for exactly the next cycle.
- R10: `err_irq` is high exactly when bit 8 is set and at least one of the two error flags is set.
- R11: With bit 0 at 0, all DMA-side and SPI-side strobes are ignored. The FIFO, the count and the flags keep their values, and `dma_req` and `dma_rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control word, 1 word count |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| dma_req | output | 1 | Transmit mode: the bridge asks the DMA engine for a word |
| dma_wr | input | 1 | DMA engine delivers a word (transmit mode) |
| dma_wdata | input | 16 | Word from memory |
| dma_rd_valid | output | 1 | Receive mode: a word is ready for the DMA engine |
| dma_rd | input | 1 | DMA engine takes the head word (receive mode) |
| dma_rdata | output | 16 | Head word of the FIFO, toward memory |
| spi_tx_start | input | 1 | SPI logic starts shifting out a word |
| spi_tx_data | output | 16 | Head word of the FIFO, toward the SPI logic |
| spi_rx_valid | input | 1 | SPI logic has received a word |
| spi_rx_data | input | 16 | Received word |
| done_irq | output | 1 | One-cycle completion interrupt |
| err_irq | output | 1 | Error interrupt level |

## Verification
The checker takes its inputs to be free of X after reset. It does not assume the DMA engine or the SPI logic follow any handshake. Strobes may arrive when they are not requested, in the wrong mode, or while the bridge is stopped or flushing, and every property must still hold. The stimulus is designed to reach those cases. It drives every input at the falling clock edge from a fixed-seed random stream. The directed cases drive out-of-turn strobes on purpose: a push into a full FIFO, a start with an empty FIFO, and strobes in the wrong mode or while stopped. Random register writes keep flushes rare and leave the bridge running most of the time, so the FIFO fills and drains often enough to reach both error conditions.

// File: rtl/spi_dma_pkg.sv
// Shared types and bit positions for the SPI DMA bridge.
// Assumes a register word of at least 11 bits.
package spi_dma_pkg;

    // Stored control fields of the control word.
    typedef struct packed {
        logic err_ie;
        logic flush;
        logic chain;
        logic done_ie;
        logic dir;
        logic en;
    } ctrl_t;

    localparam int B_EN      = 0;
    localparam int B_DIR     = 1;
    localparam int B_DONE_IE = 2;
    localparam int B_CHAIN   = 4;
    localparam int B_FLUSH   = 7;
    localparam int B_ERR_IE  = 8;
    localparam int B_OVF     = 9;
    localparam int B_UNF     = 10;

endpackage

// File: rtl/spi_dma_fifo.sv
// Circular FIFO between the DMA side and the SPI side.
// Assumes the caller never pushes when full or pops when empty.
// clr has priority over push and pop. DEPTH must be at least 2.
module spi_dma_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic                         pop,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr;
    logic [PTR_W-1:0]  wr_ptr;
    logic [LVL_W-1:0]  fill;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    // Storage write: place the incoming word at the tail.
    always_ff @(posedge clk) begin
        if (push && !clr) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointers and fill level: advance on push and pop, clear on reset or clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= step_ptr(wr_ptr);
            if (pop)  rd_ptr <= step_ptr(rd_ptr);
            case ({push, pop})
                2'b10:   fill <= fill + LVL_W'(1);
                2'b01:   fill <= fill - LVL_W'(1);
                default: fill <= fill;
            endcase
        end
    end

    assign rdata = mem[rd_ptr];
    assign level = fill;

endmodule

// File: rtl/spi_dma_regs.sv
// Control word storage, word counter and completion pulse.
// Assumes xfer is high only while the count is non-zero.
// A count write wins over a decrement in the same cycle.
module spi_dma_regs
    import spi_dma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_cnt,
    input  ctrl_t            ctrl_wdata,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             xfer,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] cnt,
    output logic             done_irq
);
    // Control word: load on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl <= ctrl_wdata;
        end
    end

    // Word counter: load on a write, otherwise count accepted words down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_cnt) begin
            cnt <= cnt_wdata;
        end else if (xfer) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Completion pulse: one cycle after the decrement that reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_irq <= 1'b0;
        end else begin
            done_irq <= xfer && !wr_cnt && (cnt == CNT_W'(1)) && ctrl.done_ie;
        end
    end

endmodule

// File: rtl/spi_dma_errs.sv
// Sticky overflow and underrun flags.
// Assumes the event inputs are already gated by mode. clr wins over a new event.
module spi_dma_errs (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ovf_evt,
    input  logic unf_evt,
    output logic ovf,
    output logic unf
);
    // Flags: set on an event, hold until a flush.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            ovf <= ovf | ovf_evt;
            unf <= unf | unf_evt;
        end
    end

endmodule

// File: rtl/spi_dma_bridge.sv
// SPI DMA bridge top: register access, mode gating of both data sides,
// FIFO, word counter, error flags and interrupts.
// Assumes REG_W >= 11, CNT_W == REG_W, DATA_W == REG_W and DEPTH >= 2.
module spi_dma_bridge
    import spi_dma_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              dma_req,
    input  logic              dma_wr,
    input  logic [DATA_W-1:0] dma_wdata,
    output logic              dma_rd_valid,
    input  logic              dma_rd,
    output logic [DATA_W-1:0] dma_rdata,
    input  logic              spi_tx_start,
    output logic [DATA_W-1:0] spi_tx_data,
    input  logic              spi_rx_valid,
    input  logic [DATA_W-1:0] spi_rx_data,
    output logic              done_irq,
    output logic              err_irq
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    ctrl_t             ctrl;
    ctrl_t             ctrl_in;
    logic [CNT_W-1:0]  cnt;
    logic [LVL_W-1:0]  fifo_level;
    logic [DATA_W-1:0] head;
    logic              wr_ctrl, wr_cnt, clr, active;
    logic              full, empty, cnt_live;
    logic              tx_side, rx_side;
    logic              tx_push, tx_pop, rx_push, rx_pop;
    logic              ovf_evt, unf_evt, xfer;
    logic              ovf, unf;

    // Register decode and the new control value.
    always_comb begin
        wr_ctrl         = reg_wr && (reg_addr == 1'b0);
        wr_cnt          = reg_wr && (reg_addr == 1'b1);
        ctrl_in.en      = reg_wdata[B_EN];
        ctrl_in.dir     = reg_wdata[B_DIR];
        ctrl_in.done_ie = reg_wdata[B_DONE_IE];
        ctrl_in.chain   = reg_wdata[B_CHAIN];
        ctrl_in.flush   = reg_wdata[B_FLUSH];
        ctrl_in.err_ie  = reg_wdata[B_ERR_IE];
    end

    // Mode gating: which side may move data, and the events it produces.
    always_comb begin
        clr      = ctrl.flush || (wr_ctrl && reg_wdata[B_FLUSH]);
        active   = ctrl.en && !ctrl.flush;
        full     = (fifo_level == LVL_W'(DEPTH));
        empty    = (fifo_level == '0);
        cnt_live = (cnt != '0);
        tx_side  = active && !ctrl.dir;
        rx_side  = active && ctrl.dir;
        dma_req      = tx_side && !full && cnt_live;
        dma_rd_valid = rx_side && !empty && cnt_live;
        tx_push  = dma_wr && dma_req;
        rx_pop   = dma_rd && dma_rd_valid;
        tx_pop   = spi_tx_start && tx_side && !empty;
        unf_evt  = spi_tx_start && tx_side && empty;
        rx_push  = spi_rx_valid && rx_side && !full;
        ovf_evt  = spi_rx_valid && rx_side && full;
        xfer     = tx_push || rx_pop;
    end

    spi_dma_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wr_cnt     (wr_cnt),
        .ctrl_wdata (ctrl_in),
        .cnt_wdata  (reg_wdata[CNT_W-1:0]),
        .xfer       (xfer),
        .ctrl       (ctrl),
        .cnt        (cnt),
        .done_irq   (done_irq)
    );

    spi_dma_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .push  (tx_push || rx_push),
        .pop   (tx_pop || rx_pop),
        .wdata (ctrl.dir ? spi_rx_data : dma_wdata),
        .rdata (head),
        .level (fifo_level)
    );

    spi_dma_errs u_errs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .ovf_evt (ovf_evt),
        .unf_evt (unf_evt),
        .ovf     (ovf),
        .unf     (unf)
    );

    assign dma_rdata   = head;
    assign spi_tx_data = head;
    assign err_irq     = (ovf || unf) && ctrl.err_ie;

    // Read mux: control word with status bits, or the word count.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == 1'b0) begin
            reg_rdata[B_EN]      = ctrl.en;
            reg_rdata[B_DIR]     = ctrl.dir;
            reg_rdata[B_DONE_IE] = ctrl.done_ie;
            reg_rdata[B_CHAIN]   = ctrl.chain;
            reg_rdata[B_FLUSH]   = ctrl.flush;
            reg_rdata[B_ERR_IE]  = ctrl.err_ie;
            reg_rdata[B_OVF]     = ovf;
            reg_rdata[B_UNF]     = unf;
        end else begin
            reg_rdata = REG_W'(cnt);
        end
    end

endmodule

// File: rtl/spi_dma_bridge_chk.sv
// Property checker for spi_dma_bridge, attached with bind.
// Assumes inputs carry no X after reset. It assumes no handshake on the data sides.
module spi_dma_bridge_chk
    import spi_dma_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int DEPTH = 4,
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input ctrl_t            ctrl,
    input logic [LVL_W-1:0] fifo_level,
    input logic             ovf,
    input logic             unf,
    input logic             dma_req,
    input logic             dma_rd_valid,
    input logic             done_irq,
    input logic             err_irq,
    input logic             reg_addr,
    input logic [REG_W-1:0] reg_rdata
);
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 1'b0) |-> (reg_rdata[3] == 1'b0 && reg_rdata[6:5] == 2'b00 &&
                                reg_rdata[REG_W-1:11] == '0));

    assert_req_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (fifo_level < LVL_W'(DEPTH)));

    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(DEPTH));

    assert_rd_has_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rd_valid |-> (fifo_level != '0));

    assert_ovf_rx_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(ctrl.dir));

    assert_unf_tx_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unf) |-> !$past(ctrl.dir));

    assert_flush_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.flush |-> (fifo_level == '0 && !ovf && !unf && !dma_req && !dma_rd_valid));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    assert_err_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> ((ovf || unf) && ctrl.err_ie));

    assert_idle_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |-> (!dma_req && !dma_rd_valid));

endmodule

bind spi_dma_bridge spi_dma_bridge_chk #(
    .REG_W (REG_W),
    .DEPTH (DEPTH),
    .LVL_W (LVL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl         (ctrl),
    .fifo_level   (fifo_level),
    .ovf          (ovf),
    .unf          (unf),
    .dma_req      (dma_req),
    .dma_rd_valid (dma_rd_valid),
    .done_irq     (done_irq),
    .err_irq      (err_irq),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata)
);

// File: tb/tb_spi_dma_bridge.sv
// Bench for spi_dma_bridge: directed corner cases, then fixed-seed random
// traffic, all checked against a model built from the requirements.
module tb_spi_dma_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        dma_req;
    logic        dma_wr = 1'b0;
    logic [15:0] dma_wdata = '0;
    logic        dma_rd_valid;
    logic        dma_rd = 1'b0;
    logic [15:0] dma_rdata;
    logic        spi_tx_start = 1'b0;
    logic [15:0] spi_tx_data;
    logic        spi_rx_valid = 1'b0;
    logic [15:0] spi_rx_data = '0;
    logic        done_irq;
    logic        err_irq;

    int nchecks = 0;
    int nfails  = 0;
    bit finished = 1'b0;

    // Model state
    bit          m_en, m_dir, m_die, m_chain, m_flush, m_eie, m_ovf, m_unf, m_done;
    logic [15:0] m_cnt;
    logic [15:0] m_q[$];

    always #10 clk = ~clk;

    spi_dma_bridge dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req),
        .dma_wr(dma_wr), .dma_wdata(dma_wdata), .dma_rd_valid(dma_rd_valid),
        .dma_rd(dma_rd), .dma_rdata(dma_rdata), .spi_tx_start(spi_tx_start),
        .spi_tx_data(spi_tx_data), .spi_rx_valid(spi_rx_valid),
        .spi_rx_data(spi_rx_data), .done_irq(done_irq), .err_irq(err_irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (!ok) begin
            nfails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rdata();
        if (reg_addr == 1'b0)
            return {5'b0, m_unf, m_ovf, m_eie, m_flush, 2'b0, m_chain, 1'b0, m_die, m_dir, m_en};
        return m_cnt;
    endfunction

    function automatic bit exp_req();
        return m_en && !m_flush && !m_dir && (m_q.size() < 4) && (m_cnt != 0);
    endfunction

    function automatic bit exp_rdv();
        return m_en && !m_flush && m_dir && (m_q.size() > 0) && (m_cnt != 0);
    endfunction

    // Next model state from the state before the edge and the held inputs.
    task automatic model_step();
        bit wc, wn, clr, act, full, empty, req, rdv;
        bit txpush, rxpop, txpop, unf_e, rxpush, ovf_e, xfer;
        wc    = reg_wr && reg_addr == 1'b0;
        wn    = reg_wr && reg_addr == 1'b1;
        clr   = m_flush || (wc && reg_wdata[7]);
        act   = m_en && !m_flush;
        full  = m_q.size() == 4;
        empty = m_q.size() == 0;
        req   = exp_req();
        rdv   = exp_rdv();
        txpush = dma_wr && req;
        rxpop  = dma_rd && rdv;
        txpop  = spi_tx_start && act && !m_dir && !empty;
        unf_e  = spi_tx_start && act && !m_dir && empty;
        rxpush = spi_rx_valid && act && m_dir && !full;
        ovf_e  = spi_rx_valid && act && m_dir && full;
        xfer   = txpush || rxpop;
        m_done = xfer && !wn && (m_cnt == 16'd1) && m_die;
        if (wn) m_cnt = reg_wdata;
        else if (xfer) m_cnt = m_cnt - 16'd1;
        if (clr) begin
            m_q.delete();
            m_ovf = 1'b0;
            m_unf = 1'b0;
        end else begin
            if (txpop || rxpop) void'(m_q.pop_front());
            if (txpush) m_q.push_back(dma_wdata);
            if (rxpush) m_q.push_back(spi_rx_data);
            m_ovf = m_ovf | ovf_e;
            m_unf = m_unf | unf_e;
        end
        if (wc) begin
            m_en = reg_wdata[0]; m_dir = reg_wdata[1]; m_die = reg_wdata[2];
            m_chain = reg_wdata[4]; m_flush = reg_wdata[7]; m_eie = reg_wdata[8];
        end
    endtask

    // One clock: update the model at the edge, compare outputs at the falling edge.
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(reg_rdata === exp_rdata(), "R2/R9 reg_rdata", reg_rdata, exp_rdata());
        chk(dma_req === exp_req(), "R3/R11 dma_req", dma_req, exp_req());
        chk(dma_rd_valid === exp_rdv(), "R5/R11 dma_rd_valid", dma_rd_valid, exp_rdv());
        if (m_q.size() > 0) begin
            chk(dma_rdata === m_q[0], "R3/R5 dma_rdata", dma_rdata, m_q[0]);
            chk(spi_tx_data === m_q[0], "R4 spi_tx_data", spi_tx_data, m_q[0]);
        end
        chk(done_irq === m_done, "R9 done_irq", done_irq, m_done);
        chk(err_irq === ((m_ovf || m_unf) && m_eie), "R10 err_irq", err_irq, (m_ovf || m_unf) && m_eie);
    endtask

    task automatic wr_reg(input bit a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input bit a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            nchecks++;
            nfails++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd2024));
        m_en = 0; m_dir = 0; m_die = 0; m_chain = 0; m_flush = 0; m_eie = 0;
        m_ovf = 0; m_unf = 0; m_done = 0; m_cnt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(0, v); chk(v == 16'h0000, "R1 control after reset", v, 0);
        rd(1, v); chk(v == 16'h0000, "R1 count after reset", v, 0);
        chk(!done_irq && !err_irq && !dma_req && !dma_rd_valid, "R1 outputs idle",
            {done_irq, err_irq, dma_req, dma_rd_valid}, 0);

        // R2: readback, reserved bits and status bits not writable
        wr_reg(0, 16'hFFFF);
        rd(0, v); chk(v == 16'h0197, "R2 readback all ones", v, 16'h0197);
        wr_reg(0, 16'h0000);
        rd(0, v); chk(v == 16'h0000, "R2 readback zero", v, 0);

        // R3/R4: transmit fill, full, ignored push, order
        wr_reg(1, 16'd10);
        wr_reg(0, 16'h0001);
        for (int i = 0; i < 4; i++) begin
            dma_wr = 1'b1; dma_wdata = 16'hA0 + 16'(i);
            cyc();
        end
        dma_wr = 1'b0;
        chk(dma_req == 1'b0, "R3 dma_req low when full", dma_req, 0);
        dma_wr = 1'b1; dma_wdata = 16'h0BAD;
        cyc();
        dma_wr = 1'b0;
        rd(1, v); chk(v == 16'd6, "R3 push while full ignored", v, 6);
        for (int i = 0; i < 4; i++) begin
            chk(spi_tx_data == 16'hA0 + 16'(i), "R4 transmit order", spi_tx_data, 16'hA0 + i);
            spi_tx_start = 1'b1;
            cyc();
        end
        // R7: start with empty FIFO
        cyc();
        spi_tx_start = 1'b0;
        rd(0, v); chk(v == 16'h0401, "R7 underrun set", v, 16'h0401);
        chk(err_irq == 1'b0, "R10 masked error", err_irq, 0);
        wr_reg(0, 16'h0101);
        chk(err_irq == 1'b1, "R10 error interrupt", err_irq, 1);
        rd(0, v); chk(v == 16'h0501, "R7 underrun sticky across write", v, 16'h0501);

        // R8: flush holds
        wr_reg(0, 16'h0181);
        rd(0, v); chk(v == 16'h0181, "R8 flags cleared by flush", v, 16'h0181);
        dma_wr = 1'b1; cyc(); cyc(); dma_wr = 1'b0;
        chk(dma_req == 1'b0, "R8 no request while flushing", dma_req, 0);
        rd(1, v); chk(v == 16'd6, "R8 count held while flushing", v, 6);
        rd(0, v); chk(v[7] == 1'b1, "R8 flush bit stays set", v[7], 1);
        wr_reg(0, 16'h0001);
        rd(0, v); chk(v == 16'h0001, "R8 flush released", v, 1);

        // R5/R6: receive fill and overflow
        wr_reg(1, 16'd3);
        wr_reg(0, 16'h0003);
        for (int i = 0; i < 5; i++) begin
            spi_rx_valid = 1'b1; spi_rx_data = 16'hC0 + 16'(i);
            cyc();
        end
        spi_rx_valid = 1'b0;
        rd(0, v); chk(v == 16'h0203, "R6 overflow set", v, 16'h0203);
        for (int i = 0; i < 3; i++) begin
            chk(dma_rd_valid && dma_rdata == 16'hC0 + 16'(i), "R5 receive order", dma_rdata, 16'hC0 + i);
            dma_rd = 1'b1; cyc(); dma_rd = 1'b0;
        end
        rd(1, v); chk(v == 16'd0, "R9 count reached zero", v, 0);
        chk(dma_rd_valid == 1'b0, "R9 no valid at zero count", dma_rd_valid, 0);

        // R9: completion pulse
        wr_reg(0, 16'h0007);
        wr_reg(1, 16'd1);
        dma_rd = 1'b1; cyc(); dma_rd = 1'b0;
        chk(done_irq == 1'b1, "R9 done pulse high", done_irq, 1);
        cyc();
        chk(done_irq == 1'b0, "R9 done pulse one cycle", done_irq, 0);

        // R7: no underrun in receive mode
        spi_tx_start = 1'b1; cyc(); spi_tx_start = 1'b0;
        rd(0, v); chk(v == 16'h0207, "R7 no underrun in receive mode", v, 16'h0207);

        // R6: no overflow in transmit mode
        wr_reg(0, 16'h0080);
        wr_reg(0, 16'h0001);
        wr_reg(1, 16'd8);
        for (int i = 0; i < 4; i++) begin
            dma_wr = 1'b1; dma_wdata = 16'hD0 + 16'(i); cyc();
        end
        dma_wr = 1'b0;
        spi_rx_valid = 1'b1; cyc(); spi_rx_valid = 1'b0;
        rd(0, v); chk(v == 16'h0001, "R6 no overflow in transmit mode", v, 1);

        // R11: stopped bridge ignores strobes
        wr_reg(0, 16'h0000);
        chk(dma_req == 1'b0, "R11 no request when stopped", dma_req, 0);
        dma_wr = 1'b1; dma_rd = 1'b1; spi_tx_start = 1'b1; spi_rx_valid = 1'b1;
        repeat (3) cyc();
        dma_wr = 1'b0; dma_rd = 1'b0; spi_tx_start = 1'b0; spi_rx_valid = 1'b0;
        rd(1, v); chk(v == 16'd4, "R11 count unchanged", v, 4);
        rd(0, v); chk(v == 16'h0000, "R11 no flags when stopped", v, 0);
        wr_reg(0, 16'h0001);
        chk(spi_tx_data == 16'hD0, "R11 FIFO untouched", spi_tx_data, 16'hD0);

        // Random traffic against the model
        for (int n = 0; n < 6000; n++) begin
            logic [15:0] w;
            reg_wr = 1'b0;
            if ($urandom % 40 == 0) begin
                w = 16'($urandom);
                w[7] = ($urandom % 8 == 0);
                w[0] = ($urandom % 6 != 0);
                reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = w;
            end else if ($urandom % 30 == 0) begin
                reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 16'($urandom % 21);
            end else begin
                reg_addr = 1'($urandom);
                reg_wdata = 16'($urandom);
            end
            dma_wr       = 1'($urandom);
            dma_wdata    = 16'($urandom);
            dma_rd       = 1'($urandom);
            spi_tx_start = ($urandom % 3 == 0);
            spi_rx_valid = ($urandom % 3 == 0);
            spi_rx_data  = 16'($urandom);
            cyc();
        end
        reg_wr = 1'b0;

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
        $finish;
    end

endmodule